// File: doc/BRIEF.md
# Paired-Word Read Buffer Sequencer

The sequencer sits between a bus-side read port and a RAM whose every access returns two neighbouring words at once: an even word and the odd word that follows it. Each word is 22 bits wide, 16 of data and 6 of check bits, and arrives already corrected on a simple input with a valid strobe. The block holds the returned pair in a latch, decides which word leaves on which cycle, and remembers which pair the latch holds. When a later burst word already sits in the latch, the block serves it without another RAM access.

Two modes are selected when a request starts. In single-word mode a plain read delivers only the requested word, and a burst delivers one word per request, climbing one word address at a time. A burst that starts on an odd address drops the even word of its first pair. In paired mode both words of a pair leave on consecutive cycles: the requested word first, then its partner. A paired burst is aligned down to an even address and fetches a fresh pair for each continuation. Writes elsewhere in the system are snooped, so that a stale pair is never served from the latch.

Top module: `pairbuf_seq`

## Requirements
- R1: A start request (`req_start` while `req_ready`) issues exactly one `ram_req` pulse, on the next cycle, for pair address `req_waddr >> 1`. It does so even when that pair is already latched.
- R2: Single-word mode without burst: exactly one word leaves, on the cycle after `ram_rvalid` is sampled. It is the word at the requested address, taken from `ram_even` when address bit 0 is 0 and from `ram_odd` when it is 1.
- R3: Paired mode: the requested word leaves first, and the other word of the same pair leaves on the very next cycle (address with bit 0 inverted).
- R4: Single-word burst on an even address: on a continuation (`req_next` while `req_ready`), the odd word leaves on the next cycle straight from the latch, with no `ram_req`.
- R5: Single-word burst on an odd address: the even word of the first pair is never output. The first continuation fetches the next pair and outputs its even word. The second continuation serves that pair's odd word from the latch.
- R6: In a single-word burst, every continuation outputs the word at the previous word address plus one.
- R7: Paired-mode burst: the start address is aligned down to even. Each continuation fetches the following pair and outputs its even word and then its odd word on consecutive cycles.
- R8: A write strobe (`wr_valid`) whose address falls in the latched pair marks the latch empty, so the next continuation into that pair fetches from RAM. This applies even when the write arrives in the same cycle as the continuation. A write to any other pair has no effect.
- R9: `req_ready` is low while a fetch or a paired second word is outstanding. Start and continuation requests made then are ignored.
- R10: After reset, `bus_valid` and `ram_req` are low, `req_ready` is high and the latch holds nothing.
- R11: `ram_req` is a one-cycle pulse and is never high in the same cycle as `bus_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_mode | input | 1 | 1 = paired mode, 0 = single-word mode; sampled at a start request |
| req_start | input | 1 | Start a new read at `req_waddr` |
| req_burst | input | 1 | With `req_start`: the read is a burst |
| req_next | input | 1 | Continue the running burst by one step |
| req_waddr | input | ADDR_W | Word address of a start request |
| req_ready | output | 1 | Start or continuation requests are accepted |
| ram_req | output | 1 | One-cycle RAM read request |
| ram_pair | output | ADDR_W-1 | Pair address of the RAM read |
| ram_rvalid | input | 1 | RAM pair returned (corrected) |
| ram_even | input | DATA_W+CHK_W | Even word of the returned pair |
| ram_odd | input | DATA_W+CHK_W | Odd word of the returned pair |
| wr_valid | input | 1 | A write to memory is taking place |
| wr_waddr | input | ADDR_W | Word address of that write |
| bus_valid | output | 1 | A word is on the bus this cycle |
| bus_waddr | output | ADDR_W | Word address of the outgoing word |
| bus_word | output | DATA_W+CHK_W | Outgoing word, data and check bits |

## Verification
Plain reads are tried on an even and an odd address of the same pair in both modes. This separates the requested-word selection and the paired order from a wrongly reused latch. Single-word bursts starting on even and odd addresses separate serving from the latch from refetching, and they show whether the dropped even word leaks out. Paired bursts started on an odd address check the alignment. Snooped writes are applied to the latched pair, to another pair, and in the same cycle as a continuation; the resulting RAM traffic shows whether invalidation acts and when. Requests made while a fetch is outstanding must produce no extra RAM traffic.

// File: rtl/pairbuf_pkg.sv
package pairbuf_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_FETCH  = 2'd1,
        SQ_SECOND = 2'd2,
        SQ_READY  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/pairbuf_latch.sv
module pairbuf_latch #(
    parameter int PAIR_W = 13,
    parameter int WORD_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAIR_W-1:0] load_pair,
    input  logic [WORD_W-1:0] load_even,
    input  logic [WORD_W-1:0] load_odd,
    input  logic              wr_valid,
    input  logic [PAIR_W-1:0] wr_pair,
    input  logic [PAIR_W-1:0] probe_pair,
    output logic              hit,
    output logic [WORD_W-1:0] even_q,
    output logic [WORD_W-1:0] odd_q
);

    typedef struct packed {
        logic              valid;
        logic [PAIR_W-1:0] pair;
        logic [WORD_W-1:0] even;
        logic [WORD_W-1:0] odd;
    } latch_s;

    latch_s q, d;
    logic   wr_match;

    always_comb begin
        wr_match = wr_valid && (wr_pair == q.pair);
        d = q;
        if (load) begin
            d.valid = !(wr_valid && (wr_pair == load_pair));
            d.pair  = load_pair;
            d.even  = load_even;
            d.odd   = load_odd;
        end else if (wr_match) begin
            d.valid = 1'b0;
        end
        // a write seen this cycle already counts against the stored pair
        hit = q.valid && !wr_match && (probe_pair == q.pair);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign even_q = q.even;
    assign odd_q  = q.odd;

endmodule

// File: rtl/pairbuf_ctrl.sv
module pairbuf_ctrl
    import pairbuf_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int WORD_W = 22,
    localparam int PAIR_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_mode,
    input  logic              req_start,
    input  logic              req_burst,
    input  logic              req_next,
    input  logic [ADDR_W-1:0] req_waddr,
    input  logic              ram_rvalid,
    input  logic [WORD_W-1:0] ram_even,
    input  logic [WORD_W-1:0] ram_odd,
    input  logic [WORD_W-1:0] lat_even,
    input  logic [WORD_W-1:0] lat_odd,
    input  logic              lat_hit,
    output logic [PAIR_W-1:0] probe_pair,
    output logic              load,
    output logic              req_ready,
    output logic              ram_req,
    output logic [PAIR_W-1:0] ram_pair,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_waddr,
    output logic [WORD_W-1:0] bus_word
);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] cur;
        logic              burst;
        logic              pmode;
        logic              bus_valid;
        logic [ADDR_W-1:0] bus_waddr;
        logic [WORD_W-1:0] bus_word;
        logic              ram_req;
        logic [PAIR_W-1:0] ram_pair;
    } ctrl_s;

    ctrl_s             q, d;
    logic [ADDR_W-1:0] nxt_addr;
    logic [ADDR_W-1:0] start_addr;

    always_comb begin
        d           = q;
        d.bus_valid = 1'b0;
        d.ram_req   = 1'b0;
        load        = 1'b0;

        nxt_addr = q.pmode ? {q.cur[ADDR_W-1:1] + PAIR_W'(1), 1'b0}
                           : q.cur + ADDR_W'(1);
        start_addr = (pair_mode && req_burst) ? {req_waddr[ADDR_W-1:1], 1'b0}
                                              : req_waddr;
        probe_pair = nxt_addr[ADDR_W-1:1];

        case (q.st)
            SQ_IDLE, SQ_READY: begin
                if (req_start) begin
                    d.cur      = start_addr;
                    d.burst    = req_burst;
                    d.pmode    = pair_mode;
                    d.ram_req  = 1'b1;
                    d.ram_pair = start_addr[ADDR_W-1:1];
                    d.st       = SQ_FETCH;
                end else if ((q.st == SQ_READY) && req_next) begin
                    d.cur = nxt_addr;
                    if (!q.pmode && lat_hit) begin
                        d.bus_valid = 1'b1;
                        d.bus_waddr = nxt_addr;
                        d.bus_word  = nxt_addr[0] ? lat_odd : lat_even;
                    end else begin
                        d.ram_req  = 1'b1;
                        d.ram_pair = nxt_addr[ADDR_W-1:1];
                        d.st       = SQ_FETCH;
                    end
                end
            end
            SQ_FETCH: begin
                if (ram_rvalid) begin
                    load        = 1'b1;
                    d.bus_valid = 1'b1;
                    d.bus_waddr = q.cur;
                    d.bus_word  = q.cur[0] ? ram_odd : ram_even;
                    if (q.pmode)      d.st = SQ_SECOND;
                    else if (q.burst) d.st = SQ_READY;
                    else              d.st = SQ_IDLE;
                end
            end
            SQ_SECOND: begin
                d.bus_valid = 1'b1;
                d.bus_waddr = {q.cur[ADDR_W-1:1], ~q.cur[0]};
                d.bus_word  = q.cur[0] ? lat_even : lat_odd;
                d.st        = q.burst ? SQ_READY : SQ_IDLE;
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SQ_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == SQ_IDLE) || (q.st == SQ_READY);
    assign ram_req   = q.ram_req;
    assign ram_pair  = q.ram_pair;
    assign bus_valid = q.bus_valid;
    assign bus_waddr = q.bus_waddr;
    assign bus_word  = q.bus_word;

endmodule

// File: rtl/pairbuf_seq.sv
module pairbuf_seq #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16,
    parameter int CHK_W  = 6,
    localparam int WORD_W = DATA_W + CHK_W,
    localparam int PAIR_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_mode,
    input  logic              req_start,
    input  logic              req_burst,
    input  logic              req_next,
    input  logic [ADDR_W-1:0] req_waddr,
    output logic              req_ready,
    output logic              ram_req,
    output logic [PAIR_W-1:0] ram_pair,
    input  logic              ram_rvalid,
    input  logic [WORD_W-1:0] ram_even,
    input  logic [WORD_W-1:0] ram_odd,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_waddr,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_waddr,
    output logic [WORD_W-1:0] bus_word
);

    logic              load;
    logic              lat_hit;
    logic [PAIR_W-1:0] probe_pair;
    logic [WORD_W-1:0] lat_even;
    logic [WORD_W-1:0] lat_odd;

    pairbuf_ctrl #(
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_mode  (pair_mode),
        .req_start  (req_start),
        .req_burst  (req_burst),
        .req_next   (req_next),
        .req_waddr  (req_waddr),
        .ram_rvalid (ram_rvalid),
        .ram_even   (ram_even),
        .ram_odd    (ram_odd),
        .lat_even   (lat_even),
        .lat_odd    (lat_odd),
        .lat_hit    (lat_hit),
        .probe_pair (probe_pair),
        .load       (load),
        .req_ready  (req_ready),
        .ram_req    (ram_req),
        .ram_pair   (ram_pair),
        .bus_valid  (bus_valid),
        .bus_waddr  (bus_waddr),
        .bus_word   (bus_word)
    );

    pairbuf_latch #(
        .PAIR_W(PAIR_W),
        .WORD_W(WORD_W)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_pair  (ram_pair),
        .load_even  (ram_even),
        .load_odd   (ram_odd),
        .wr_valid   (wr_valid),
        .wr_pair    (wr_waddr[ADDR_W-1:1]),
        .probe_pair (probe_pair),
        .hit        (lat_hit),
        .even_q     (lat_even),
        .odd_q      (lat_odd)
    );

endmodule

// File: rtl/pairbuf_chk.sv
module pairbuf_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pair_mode,
    input logic              req_ready,
    input logic              ram_req,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_waddr
);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!bus_valid && !ram_req && req_ready));

    // R11
    ram_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req |=> !ram_req);

    // R11
    req_word_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_req && bus_valid));

    // R9
    busy_on_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req |-> !req_ready);

    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && $past(bus_valid) && !pair_mode && !$past(pair_mode))
        |-> (bus_waddr == ADDR_W'($past(bus_waddr) + 1'b1)));

    // R3
    pair_partner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && $past(bus_valid) && pair_mode && $past(pair_mode))
        |-> (bus_waddr == ($past(bus_waddr) ^ ADDR_W'(1))));

endmodule

bind pairbuf_seq pairbuf_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pair_mode (pair_mode),
    .req_ready (req_ready),
    .ram_req   (ram_req),
    .bus_valid (bus_valid),
    .bus_waddr (bus_waddr)
);

// File: tb/pairbuf_seq_tb_top.sv
module pairbuf_seq_tb_top;

    localparam int AW = 14;
    localparam int DW = 16;
    localparam int CW = 6;
    localparam int WW = DW + CW;
    localparam int MEM_N = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pair_mode = 1'b0;
    logic          req_start = 1'b0;
    logic          req_burst = 1'b0;
    logic          req_next = 1'b0;
    logic [AW-1:0] req_waddr = '0;
    logic          req_ready;
    logic          ram_req;
    logic [AW-2:0] ram_pair;
    logic          ram_rvalid = 1'b0;
    logic [WW-1:0] ram_even = '0;
    logic [WW-1:0] ram_odd = '0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_waddr = '0;
    logic          bus_valid;
    logic [AW-1:0] bus_waddr;
    logic [WW-1:0] bus_word;

    pairbuf_seq #(.ADDR_W(AW), .DATA_W(DW), .CHK_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode),
        .req_start(req_start), .req_burst(req_burst), .req_next(req_next),
        .req_waddr(req_waddr), .req_ready(req_ready),
        .ram_req(ram_req), .ram_pair(ram_pair), .ram_rvalid(ram_rvalid),
        .ram_even(ram_even), .ram_odd(ram_odd),
        .wr_valid(wr_valid), .wr_waddr(wr_waddr),
        .bus_valid(bus_valid), .bus_waddr(bus_waddr), .bus_word(bus_word)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [WW-1:0] mem [MEM_N];

    // expected events
    int    eb_addr[$];
    int    eb_cyc[$];
    logic [WW-1:0] eb_data[$];
    string eb_tag[$];
    int    er_pair[$];
    int    er_cyc[$];
    string er_tag[$];

    // behavioural view of the running request
    int m_cur = 0;
    int m_lat_pair = -1;
    bit m_pm = 1'b0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] init_word(int a);
        logic [DW-1:0] dd;
        logic [CW-1:0] cc;
        dd = DW'(a * 16'h0137) ^ 16'hA5C3;
        cc = CW'(a) ^ 6'h15;
        return {dd, cc};
    endfunction

    function automatic void exp_bus(int a, int c, string tag);
        eb_addr.push_back(a);
        eb_cyc.push_back(c);
        eb_data.push_back(mem[a % MEM_N]);
        eb_tag.push_back(tag);
    endfunction

    function automatic void exp_ram(int p, int c, string tag);
        er_pair.push_back(p);
        er_cyc.push_back(c);
        er_tag.push_back(tag);
    endfunction

    // RAM responder: data returned two cycles after the request is seen
    int rsp_cnt = 0;
    int rsp_pair = 0;
    always @(negedge clk) begin
        ram_rvalid <= 1'b0;
        if (rst_n && ram_req) begin
            rsp_pair = int'(ram_pair);
            rsp_cnt  = 1;
        end else if (rsp_cnt == 1) begin
            rsp_cnt = 0;
            ram_rvalid <= 1'b1;
            ram_even   <= mem[(rsp_pair * 2) % MEM_N];
            ram_odd    <= mem[(rsp_pair * 2 + 1) % MEM_N];
        end
    end

    // monitor, compared every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ram_req) begin
                if (er_pair.size() == 0) begin
                    chk(1'b0, "R1", "unexpected ram_req pair", longint'(ram_pair), -1);
                end else begin
                    automatic int    p = er_pair.pop_front();
                    automatic int    c = er_cyc.pop_front();
                    automatic string t = er_tag.pop_front();
                    chk(int'(ram_pair) == p, t, "ram_pair", longint'(ram_pair), p);
                    chk(cyc == c, t, "ram_req cycle", cyc, c);
                end
            end
            if (bus_valid) begin
                if (eb_addr.size() == 0) begin
                    chk(1'b0, "R2", "unexpected bus word at", longint'(bus_waddr), -1);
                end else begin
                    automatic int            a = eb_addr.pop_front();
                    automatic int            c = eb_cyc.pop_front();
                    automatic logic [WW-1:0] v = eb_data.pop_front();
                    automatic string         t = eb_tag.pop_front();
                    chk(int'(bus_waddr) == a, t, "bus_waddr", longint'(bus_waddr), a);
                    chk(bus_word == v, t, "bus_word", longint'(bus_word), longint'(v));
                    chk(cyc == c, t, "bus cycle", cyc, c);
                end
            end
        end
    end

    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic go_start(int a, bit burst, bit pm, string tag);
        int n;
        int first;
        wait_ready();
        n = cyc;
        first = (pm && burst) ? (a & ~1) : a;
        pair_mode = pm;
        req_start = 1'b1;
        req_burst = burst;
        req_waddr = AW'(a);
        exp_ram(first >> 1, n + 1, tag);
        exp_bus(first, n + 3, tag);
        if (pm) exp_bus(first ^ 1, n + 4, tag);
        m_cur = first;
        m_lat_pair = first >> 1;
        m_pm = pm;
        @(negedge clk);
        req_start = 1'b0;
        req_burst = 1'b0;
    endtask

    // continuation, optionally with a write in the same cycle
    task automatic go_next(string tag, int wa = -1, logic [WW-1:0] wv = '0);
        int n;
        int na;
        wait_ready();
        n = cyc;
        req_next = 1'b1;
        if (wa >= 0) begin
            wr_valid = 1'b1;
            wr_waddr = AW'(wa);
            mem[wa % MEM_N] = wv;
            if ((wa >> 1) == m_lat_pair) m_lat_pair = -1;
        end
        if (m_pm) begin
            na = (m_cur & ~1) + 2;
            exp_ram(na >> 1, n + 1, tag);
            exp_bus(na, n + 3, tag);
            exp_bus(na + 1, n + 4, tag);
            m_lat_pair = na >> 1;
        end else begin
            na = m_cur + 1;
            if ((na >> 1) == m_lat_pair) begin
                exp_bus(na, n + 1, tag);
            end else begin
                exp_ram(na >> 1, n + 1, tag);
                exp_bus(na, n + 3, tag);
                m_lat_pair = na >> 1;
            end
        end
        m_cur = na;
        @(negedge clk);
        req_next = 1'b0;
        wr_valid = 1'b0;
    endtask

    task automatic wr_to(int a, logic [WW-1:0] v);
        wr_valid = 1'b1;
        wr_waddr = AW'(a);
        mem[a % MEM_N] = v;
        if ((a >> 1) == m_lat_pair) m_lat_pair = -1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R9", "watchdog expired, cycle", cyc, 0);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < MEM_N; i++) mem[i] = init_word(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(bus_valid == 1'b0, "R10", "bus_valid after reset", bus_valid, 0);
        chk(ram_req == 1'b0, "R10", "ram_req after reset", ram_req, 0);
        chk(req_ready == 1'b1, "R10", "req_ready after reset", req_ready, 1);

        // R2 plain single-word reads, even then odd of the same pair
        go_start(20, 1'b0, 1'b0, "R2");
        drain();
        // R1 same pair again: must refetch
        go_start(21, 1'b0, 1'b0, "R1");
        drain();

        // R3 paired order, odd first then even first
        go_start(33, 1'b0, 1'b1, "R3");
        drain();
        go_start(34, 1'b0, 1'b1, "R3");
        drain();

        // R4 / R6 single-word burst from an even address
        go_start(40, 1'b1, 1'b0, "R4");
        go_next("R4");
        go_next("R6");
        go_next("R6");
        drain();

        // R5 single-word burst from an odd address
        go_start(51, 1'b1, 1'b0, "R5");
        go_next("R5");
        go_next("R5");
        drain();

        // R7 paired burst started on an odd address
        go_start(61, 1'b1, 1'b1, "R7");
        go_next("R7");
        go_next("R7");
        drain();

        // R8 write into the latched pair forces a refetch with new data
        go_start(70, 1'b1, 1'b0, "R8");
        wait_ready();
        wr_to(71, 22'h2ABCD5);
        go_next("R8");
        drain();
        // R8 write to another pair leaves the latch usable
        go_start(80, 1'b1, 1'b0, "R8");
        wait_ready();
        wr_to(90, 22'h1F0F0F);
        go_next("R8");
        drain();
        // R8 write in the same cycle as the continuation
        go_start(100, 1'b1, 1'b0, "R8");
        go_next("R8", 101, 22'h0C3C3C);
        drain();

        // R9 requests while a fetch is outstanding are ignored
        go_start(110, 1'b0, 1'b0, "R9");
        chk(req_ready == 1'b0, "R9", "req_ready during fetch", req_ready, 0);
        req_start = 1'b1;
        req_next  = 1'b1;
        req_waddr = AW'(6);
        @(negedge clk);
        req_start = 1'b0;
        req_next  = 1'b0;
        drain();

        // R1 a new start ends a running burst
        go_start(120, 1'b1, 1'b0, "R1");
        go_start(5, 1'b0, 1'b0, "R1");
        drain();

        chk(eb_addr.size() == 0, "R2", "missing bus words", eb_addr.size(), 0);
        chk(er_pair.size() == 0, "R1", "missing ram requests", er_pair.size(), 0);
        finish_run();
    end

endmodule